// File: doc/BRIEF.md
# SHA-256 Message Byte Packer and Padder

This block sits between a byte-granular write path and a SHA-256 compression engine. Each write brings a 32-bit word and a byte enable. Before packing, a byte-order swap can convert little-endian words into the big-endian order the hash expects. The block gathers the enabled bytes into a stream of full 32-bit words and counts the message length in bits.

On the process command the block appends the standard SHA-256 tail to the stream. The tail is a marker byte 0x80, zero fill, and the 64-bit bit length in the last two words of a 512-bit block. The output is therefore a whole number of blocks. The output is a valid/ready word stream. Each word carries a flag for the end of a block and a flag for the last word of the message. A length override lets a keyed second pass emit a length other than the counted one.

Top module: `sha_pad_top`

## Requirements
- R1: The swap setting resets to enabled. When it is enabled, the input word and its byte enables are both mirrored by byte: lane i takes lane 3-i, so word bits 7:0 become the first message byte.
- R2: A configuration write (`cfg_we_i`) takes effect only while the block is idle. A write during a message is ignored and the message keeps the swap setting it started with.
- R3: Enabled bytes are taken from the highest lane down and appended to the message in that order. Each group of four message bytes leaves as one output word, first byte in bits 31:24. Disabled lanes carry no data.
- R4: The length counter adds 8 for each enabled byte accepted. A start command in idle clears it. It changes at no other time. It is visible as `len_hi_o`:`len_lo_o`, and its low three bits are always zero.
- R5: The word after the last data bytes holds those bytes followed by 0x80 in the next byte lane, with zeros below. If the data ends on a word boundary this word is 0x80000000.
- R6: Zero words follow up to word 13 of a block. Words 14 and 15 carry the 64-bit length, upper half first. An empty message gives 0x80000000, thirteen zero words, then two zero words.
- R7: If the marker word falls in word 14 or 15 of a block, the rest of that block and words 0 to 13 of one extra block are zero before the length words.
- R8: If `len_ovr_en_i` is high at the process command, the length words carry `len_ovr_i` instead of the counted length. The counted length registers are not affected.
- R9: `out_blk_end_o` is high on every 16th word transferred. `out_final_o` is high only on the last length word. After that word the block is idle, with no valid output and no input ready.
- R10: `out_valid_o` stays high with data and flags unchanged until `out_ready_i`. `in_ready_o` is low whenever the output holds a word that is not being taken, while a process command is present, and outside a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the swap setting (idle only) |
| cfg_swap_i | input | 1 | New swap setting |
| start_i | input | 1 | Begin a message: clear length and packer |
| process_i | input | 1 | End the message and emit the padding |
| len_ovr_en_i | input | 1 | Use the override length in the tail |
| len_ovr_i | input | 64 | Override length in bits |
| in_valid_i | input | 1 | Message write present |
| in_data_i | input | 32 | Message write data |
| in_be_i | input | 4 | Byte enables, bit i for bits 8i+7:8i |
| in_ready_o | output | 1 | Message write accepted this cycle |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output word |
| out_blk_end_o | output | 1 | Word is the last of a 512-bit block |
| out_final_o | output | 1 | Word is the last of the message |
| out_ready_i | input | 1 | Downstream takes the word |
| len_lo_o | output | 32 | Counted length in bits, lower half |
| len_hi_o | output | 32 | Counted length in bits, upper half |

## Verification
A write that completes a word makes that word valid one edge after the accepting edge. The length outputs change at that same edge. After a process command, the marker word becomes valid two edges later, and each padding word follows one edge after the previous word is taken. The bench does not predict absolute cycles. It records every word at the moment of its handshake and samples half a cycle away from the edge. It then compares the recorded sequence with the padded image computed from the message bytes. The length outputs and the idle state are read only after the final word has been taken, when they can no longer move.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MSG,
      ST_MARK,
      ST_ZERO,
      ST_LHI,
      ST_LLO
   } pad_state_e;
endpackage

// File: rtl/sha_pad_swap.sv
module sha_pad_swap #(
   parameter int DATA_W   = 32,
   parameter bit SWAP_RST = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cfg_we_i,
   input  logic                cfg_val_i,
   input  logic                idle_i,
   input  logic [DATA_W-1:0]   data_i,
   input  logic [DATA_W/8-1:0] be_i,
   output logic [DATA_W-1:0]   data_o,
   output logic [DATA_W/8-1:0] be_o
);
   localparam int NB = DATA_W / 8;

   logic swap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 swap_q <= SWAP_RST;
      else if (cfg_we_i && idle_i) swap_q <= cfg_val_i;
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign data_o[8*g +: 8] = swap_q ? data_i[8*(NB-1-g) +: 8] : data_i[8*g +: 8];
      assign be_o[g]          = swap_q ? be_i[NB-1-g]            : be_i[g];
   end
endmodule

// File: rtl/sha_pad_packer.sv
module sha_pad_packer #(
   parameter int DATA_W = 32
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      clear_i,
   input  logic                      take_i,
   input  logic [DATA_W-1:0]         data_i,
   input  logic [DATA_W/8-1:0]       be_i,
   output logic [DATA_W-1:0]         word_o,
   output logic                      full_o,
   output logic [$clog2(DATA_W/8+1)-1:0] nbytes_o,
   output logic [DATA_W-1:0]         acc_o,
   output logic [$clog2(DATA_W/8)-1:0] cnt_o
);
   localparam int NB  = DATA_W / 8;
   localparam int CW  = $clog2(NB);
   localparam int NBW = $clog2(NB + 1);

   logic [DATA_W-1:0]   comp;
   logic [NBW-1:0]      n;
   logic [2*DATA_W-1:0] joined;
   logic [CW:0]         total;
   logic [DATA_W-1:0]   acc_q;
   logic [CW-1:0]       cnt_q;

   // left-align the enabled bytes, highest lane first
   always_comb begin
      int k;
      k    = 0;
      comp = '0;
      for (int i = NB - 1; i >= 0; i--) begin
         if (be_i[i]) begin
            comp[DATA_W - 8 - 8*k +: 8] = data_i[8*i +: 8];
            k = k + 1;
         end
      end
      n = NBW'(k);
   end

   assign joined = {acc_q, {DATA_W{1'b0}}} | ({comp, {DATA_W{1'b0}}} >> (8 * int'(cnt_q)));
   assign total  = (CW+1)'(cnt_q) + (CW+1)'(n);
   assign full_o = total >= (CW+1)'(NB);
   assign word_o = joined[2*DATA_W-1:DATA_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (clear_i) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (take_i) begin
         if (full_o) begin
            acc_q <= joined[DATA_W-1:0];
            cnt_q <= CW'(total - (CW+1)'(NB));
         end else begin
            acc_q <= joined[2*DATA_W-1:DATA_W];
            cnt_q <= CW'(total);
         end
      end
   end

   assign nbytes_o = n;
   assign acc_o    = acc_q;
   assign cnt_o    = cnt_q;
endmodule

// File: rtl/sha_pad_lenctr.sv
module sha_pad_lenctr #(
   parameter int LEN_W = 64,
   parameter int NBW   = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             add_i,
   input  logic [NBW-1:0]   nbytes_i,
   output logic [LEN_W-1:0] len_o
);
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      len_q <= '0;
      else if (clear_i) len_q <= '0;
      else if (add_i)   len_q <= len_q + (LEN_W'(nbytes_i) << 3);
   end

   assign len_o = len_q;
endmodule

// File: rtl/sha_pad_top.sv
module sha_pad_top import sha_pad_pkg::*; #(
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 64,
   parameter int BLK_WORDS = 16,
   parameter bit SWAP_RST  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic              cfg_swap_i,
   input  logic              start_i,
   input  logic              process_i,
   input  logic              len_ovr_en_i,
   input  logic [LEN_W-1:0]  len_ovr_i,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic [DATA_W/8-1:0] in_be_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic              out_blk_end_o,
   output logic              out_final_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] len_lo_o,
   output logic [DATA_W-1:0] len_hi_o
);
   localparam int NB  = DATA_W / 8;
   localparam int CW  = $clog2(NB);
   localparam int NBW = $clog2(NB + 1);
   localparam int PW  = $clog2(BLK_WORDS);

   initial begin
      if (DATA_W % 8 != 0 || (NB & (NB - 1)) != 0)
         $fatal(1, "DATA_W must be a power-of-two number of bytes");
      if (LEN_W != 2 * DATA_W)
         $fatal(1, "LEN_W must be two data words");
      if (BLK_WORDS < 4 || (BLK_WORDS & (BLK_WORDS - 1)) != 0)
         $fatal(1, "BLK_WORDS must be a power of two of at least 4");
   end

   pad_state_e        state_q, state_d;
   logic [PW-1:0]     wptr_q;
   logic [LEN_W-1:0]  len_emit_q, len_cnt;
   logic              idle, clear, take, slot_free, load;
   logic [DATA_W-1:0] sw_data, pk_word, pk_acc, load_data, marker;
   logic [NB-1:0]     sw_be;
   logic              pk_full, load_final;
   logic [NBW-1:0]    pk_n;
   logic [CW-1:0]     pk_cnt;
   logic              out_valid_q, out_blk_q, out_fin_q;
   logic [DATA_W-1:0] out_data_q;

   assign idle       = state_q == ST_IDLE;
   assign clear      = idle && start_i;
   assign slot_free  = !out_valid_q || out_ready_i;
   assign in_ready_o = (state_q == ST_MSG) && !process_i && slot_free;
   assign take       = in_valid_i && in_ready_o;

   sha_pad_swap #(.DATA_W(DATA_W), .SWAP_RST(SWAP_RST)) u_swap (
      .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_val_i(cfg_swap_i),
      .idle_i(idle), .data_i(in_data_i), .be_i(in_be_i), .data_o(sw_data), .be_o(sw_be));

   sha_pad_packer #(.DATA_W(DATA_W)) u_pack (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .take_i(take),
      .data_i(sw_data), .be_i(sw_be), .word_o(pk_word), .full_o(pk_full),
      .nbytes_o(pk_n), .acc_o(pk_acc), .cnt_o(pk_cnt));

   sha_pad_lenctr #(.LEN_W(LEN_W), .NBW(NBW)) u_len (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .add_i(take),
      .nbytes_i(pk_n), .len_o(len_cnt));

   assign marker = pk_acc | ({8'h80, {(DATA_W-8){1'b0}}} >> (8 * int'(pk_cnt)));

   always_comb begin
      state_d    = state_q;
      load       = 1'b0;
      load_data  = '0;
      load_final = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) state_d = ST_MSG;
         ST_MSG: begin
            if (process_i) state_d = ST_MARK;
            else if (take && pk_full) begin
               load      = 1'b1;
               load_data = pk_word;
            end
         end
         ST_MARK, ST_ZERO: if (slot_free) begin
            load      = 1'b1;
            load_data = (state_q == ST_MARK) ? marker : '0;
            state_d   = (wptr_q == PW'(BLK_WORDS - 3)) ? ST_LHI : ST_ZERO;
         end
         ST_LHI: if (slot_free) begin
            load      = 1'b1;
            load_data = len_emit_q[LEN_W-1:DATA_W];
            state_d   = ST_LLO;
         end
         ST_LLO: if (slot_free) begin
            load       = 1'b1;
            load_data  = len_emit_q[DATA_W-1:0];
            load_final = 1'b1;
            state_d    = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         wptr_q     <= '0;
         len_emit_q <= '0;
      end else begin
         state_q <= state_d;
         if (clear)     wptr_q <= '0;
         else if (load) wptr_q <= wptr_q + 1'b1;
         if (state_q == ST_MSG && process_i)
            len_emit_q <= len_ovr_en_i ? len_ovr_i : len_cnt;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
         out_blk_q   <= 1'b0;
         out_fin_q   <= 1'b0;
      end else if (load) begin
         out_valid_q <= 1'b1;
         out_data_q  <= load_data;
         out_blk_q   <= wptr_q == PW'(BLK_WORDS - 1);
         out_fin_q   <= load_final;
      end else if (out_ready_i) begin
         out_valid_q <= 1'b0;
      end
   end

   assign out_valid_o   = out_valid_q;
   assign out_data_o    = out_data_q;
   assign out_blk_end_o = out_blk_q;
   assign out_final_o   = out_fin_q;
   assign len_lo_o      = len_cnt[DATA_W-1:0];
   assign len_hi_o      = len_cnt[LEN_W-1:DATA_W];
endmodule

// File: rtl/sha_pad_chk.sv
module sha_pad_chk #(
   parameter int DATA_W    = 32,
   parameter int BLK_WORDS = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              in_valid_i,
   input logic              in_ready_o,
   input logic              out_valid_o,
   input logic [DATA_W-1:0] out_data_o,
   input logic              out_blk_end_o,
   input logic              out_final_o,
   input logic              out_ready_i,
   input logic [DATA_W-1:0] len_lo_o,
   input logic [DATA_W-1:0] len_hi_o
);
   localparam int PW = $clog2(BLK_WORDS);
   logic [PW-1:0] xfer_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         xfer_cnt <= '0;
      else if (out_valid_o && out_ready_i) xfer_cnt <= xfer_cnt + 1'b1;
   end

   // R10
   out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
                                          && $stable(out_blk_end_o) && $stable(out_final_o)));
   // R10
   in_bp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o |-> (!out_valid_o || out_ready_i));
   // R9
   blk_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_ready_i) |-> (out_blk_end_o == (xfer_cnt == PW'(BLK_WORDS - 1))));
   // R9
   final_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_ready_i && out_final_o) |=> (!out_valid_o && !in_ready_o));
   // R9
   final_on_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_final_o) |-> out_blk_end_o);
   // R4
   len_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(in_valid_i && in_ready_o) && !start_i) |=> ($stable(len_lo_o) && $stable(len_hi_o)));
   // R4
   len_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      len_lo_o[2:0] == 3'b000);
endmodule

bind sha_pad_top sha_pad_chk #(.DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .in_valid_i(in_valid_i),
   .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
   .out_blk_end_o(out_blk_end_o), .out_final_o(out_final_o), .out_ready_i(out_ready_i),
   .len_lo_o(len_lo_o), .len_hi_o(len_hi_o));

// File: tb/sha_pad_top_bench.sv
module sha_pad_top_bench;
   localparam int HALF = 10;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        cfg_we_i = 1'b0, cfg_swap_i = 1'b0;
   logic        start_i = 1'b0, process_i = 1'b0;
   logic        len_ovr_en_i = 1'b0;
   logic [63:0] len_ovr_i = '0;
   logic        in_valid_i = 1'b0;
   logic [31:0] in_data_i = '0;
   logic [3:0]  in_be_i = '0;
   logic        in_ready_o, out_valid_o, out_blk_end_o, out_final_o;
   logic        out_ready_i = 1'b1;
   logic [31:0] out_data_o, len_lo_o, len_hi_o;

   sha_pad_top u_sha_pad_top (.*);

   always #HALF clk_i = ~clk_i;

   int nchk = 0, nerr = 0;
   int ng = 0, cyc = 0;
   bit bp = 1'b0, stall_q = 1'b0;
   logic [31:0] stall_d;
   logic [31:0] got_w [0:63];
   bit          got_b [0:63];
   bit          got_f [0:63];
   logic [7:0]  msg [0:127];

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk_i) begin
      cyc++;
      out_ready_i = bp ? (cyc % 3 != 2) : 1'b1;
      #1;
      if (stall_q) chk(out_valid_o && out_data_o == stall_d, "R10 hold", out_data_o, stall_d);
      if (out_valid_o && !out_ready_i) chk(!in_ready_o, "R10 backpressure", in_ready_o, 0);
      stall_q = out_valid_o && !out_ready_i;
      stall_d = out_data_o;
      if (out_valid_o && out_ready_i && ng < 64) begin
         got_w[ng] = out_data_o;
         got_b[ng] = out_blk_end_o;
         got_f[ng] = out_final_o;
         ng++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk_i);
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   task automatic pulse_start();
      @(negedge clk_i); #2 start_i = 1'b1;
      @(negedge clk_i); #2 start_i = 1'b0;
   endtask

   task automatic pulse_proc();
      @(negedge clk_i); #2 process_i = 1'b1;
      @(negedge clk_i); #2 process_i = 1'b0;
   endtask

   task automatic cfg_write(bit v);
      @(negedge clk_i); #2 cfg_we_i = 1'b1; cfg_swap_i = v;
      @(negedge clk_i); #2 cfg_we_i = 1'b0;
   endtask

   task automatic wr(logic [31:0] d, logic [3:0] be);
      bit acc;
      @(negedge clk_i); #2;
      in_valid_i = 1'b1; in_data_i = d; in_be_i = be;
      do begin
         #5 acc = in_ready_o;
         @(negedge clk_i); #2;
      end while (!acc);
      in_valid_i = 1'b0; in_be_i = '0;
   endtask

   function automatic logic [7:0] exp_byte(int j, int L, logic [63:0] lf);
      int P;
      P = ((L + 8) / 64 + 1) * 64;
      if (j < L) return msg[j];
      if (j == L) return 8'h80;
      if (j >= P - 8) return lf[8*(P-1-j) +: 8];
      return 8'h00;
   endfunction

   // style 0: single bytes in rotating lanes; 1: words, high-lane tail;
   // 2: byte pairs in lanes 3 and 1; 3: words for swapped input (swap on)
   task automatic run_msg(int L, int style, bit ovr, logic [63:0] ovv, bit poke);
      int P, j, nw, t;
      logic [31:0] d, e;
      logic [63:0] lf;
      string tag;
      ng = 0;
      for (int k = 0; k < 128; k++) msg[k] = 8'((k * 37 + L * 5 + 1) & 255);
      pulse_start();
      j = 0;
      while (j < L) begin
         d = 32'hEEEE_EEEE;
         if (style == 0) begin
            d[8*(j%4) +: 8] = msg[j];
            wr(d, 4'(1 << (j % 4))); j += 1;
         end else if (style == 2) begin
            if (L - j >= 2) begin
               d[31:24] = msg[j]; d[15:8] = msg[j+1];
               wr(d, 4'b1010); j += 2;
            end else begin
               d[23:16] = msg[j]; wr(d, 4'b0100); j += 1;
            end
         end else begin
            t = (L - j >= 4) ? 4 : L - j;
            for (int b = 0; b < t; b++) begin
               if (style == 1) d[8*(3-b) +: 8] = msg[j+b];
               else            d[8*b +: 8]     = msg[j+b];
            end
            if (style == 1) wr(d, 4'(((1 << t) - 1) << (4 - t)));
            else            wr(d, 4'((1 << t) - 1));
            j += t;
         end
         if (poke && j <= 4) cfg_write(~(style == 3));
      end
      @(negedge clk_i); #2 len_ovr_en_i = ovr; len_ovr_i = ovv;
      pulse_proc();
      len_ovr_en_i = 1'b0;
      t = 0;
      while (!(ng > 0 && got_f[ng-1]) && ng < 64 && t < 3000) begin
         @(negedge clk_i); t++;
      end
      @(negedge clk_i); @(negedge clk_i);
      P  = ((L + 8) / 64 + 1) * 64;
      nw = P / 4;
      lf = ovr ? ovv : 64'(L) * 8;
      chk(ng == nw, "R9 word count", ng, nw);
      for (int w = 0; w < nw && w < ng; w++) begin
         e = {exp_byte(4*w, L, lf), exp_byte(4*w+1, L, lf),
              exp_byte(4*w+2, L, lf), exp_byte(4*w+3, L, lf)};
         if (w >= nw - 2)        tag = ovr ? "R8 length" : "R6 length";
         else if (4*w + 4 <= L)  tag = (style == 3) ? "R1 swapped data" : "R3 packed data";
         else if (4*w <= L)      tag = "R5 marker";
         else if (P > 64 && (L % 64) >= 56) tag = "R7 extra block";
         else                    tag = "R6 zero fill";
         if (poke) tag = "R2 cfg ignored";
         chk(got_w[w] == e, tag, got_w[w], e);
         chk(got_b[w] == (w % 16 == 15), "R9 block end", got_b[w], (w % 16 == 15));
         chk(got_f[w] == (w == nw - 1), "R9 final", got_f[w], (w == nw - 1));
      end
      chk({len_hi_o, len_lo_o} == 64'(L) * 8, ovr ? "R8 counted length" : "R4 length",
          {len_hi_o, len_lo_o}, 64'(L) * 8);
      chk(!in_ready_o && !out_valid_o, "R9 idle", {in_ready_o, out_valid_o}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      #2 rst_ni = 1'b1;
      @(negedge clk_i);
      chk(!out_valid_o && !in_ready_o, "R9 reset idle", {out_valid_o, in_ready_o}, 0);
      chk({len_hi_o, len_lo_o} == 0, "R4 reset length", {len_hi_o, len_lo_o}, 0);
      // R1: swap enabled out of reset
      run_msg(11, 3, 1'b0, '0, 1'b0);
      run_msg(0, 3, 1'b0, '0, 1'b0);
      cfg_write(1'b0);
      // R3 R5 R6 R7: sweep every length up to past one block
      for (int L = 0; L <= 70; L++) run_msg(L, 0, 1'b0, '0, 1'b0);
      bp = 1'b1;
      for (int L = 0; L <= 70; L++) run_msg(L, 1, 1'b0, '0, 1'b0);
      bp = 1'b0;
      for (int L = 50; L <= 66; L++) run_msg(L, 2, 1'b0, '0, 1'b0);
      // R8 override
      run_msg(5, 1, 1'b1, 64'h0000_0001_0000_0200, 1'b0);
      run_msg(60, 0, 1'b1, 64'h0000_0000_0000_0300, 1'b0);
      // R2: swap change mid-message ignored
      run_msg(20, 1, 1'b0, '0, 1'b1);
      run_msg(9, 1, 1'b0, '0, 1'b0);
      cfg_write(1'b1);
      run_msg(23, 3, 1'b0, '0, 1'b0);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule